// File: doc/BRIEF.md
# Halted-Core Debug Command Engine

This block executes host debug commands on the target while the CPU core is halted. A shifter front end delivers an 8-bit command code and, for commands that need one, a 16-bit data word. The engine decodes the code and carries out one of four kinds of action:

- Register reads load a 16-bit result into the output shift register.
- Register writes update the CPU register file.
- Memory-walk commands step the X pointer and access memory through a request/grant port.
- Run-control commands raise a single-cycle pulse toward the core.

The engine responds only while the debug-active flag is set. A halt pulse from the core sets the flag, and any run-control command clears it. The engine handles one command at a time. A code that arrives while a command is still in progress is dropped, and an overrun flag records it.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, dbg_active_o, illegal_o, overrun_o, rdata_valid_o, go_o, step_o and tag_go_o are all low, and PC, D, X, Y and SP all read as zero.
- R2: A pulse on halt_i sets dbg_active_o. While dbg_active_o is low, every command code and data word is ignored, so no register changes and no read data appears.
- R3: Codes 0x43, 0x44, 0x45, 0x46 and 0x47 write the next data word into PC, D, X, Y and SP respectively. The write takes effect in the cycle the word is accepted.
- R4: Codes 0x63, 0x64, 0x65, 0x66 and 0x67 return PC, D, X, Y and SP respectively as a full 16-bit word on rdata_o. rdata_valid_o pulses for one cycle, on the cycle after the code is accepted, which is well within 32 cycles.
- R5: Code 0x42 takes a data word, advances X by 2, and then writes the word to memory at the new X.
- R6: Code 0x62 advances X by 2, then reads the memory word at the new X into rdata_o. With a grant delay of up to 128 cycles, the result is valid within 150 cycles of the code.
- R7: mem_req_o stays high until mem_gnt_i is seen. mem_en_o, and with it the address, is driven only in the cycle after the grant.
- R8: Code 0x08 pulses go_o, code 0x10 pulses step_o and code 0x18 pulses tag_go_o. Each pulse lasts exactly one cycle, none of these codes takes data, and dbg_active_o goes low in the same cycle as the pulse.
- R9: An unknown code changes no register and sets illegal_o. illegal_o clears on the next accepted code.
- R10: busy_o is high from the moment a write or memory-walk code is accepted until the write commits or the memory result is latched. A code that arrives while busy_o is high is ignored and sets overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Core entered debug state (pulse) |
| cmd_valid_i | input | 1 | Command code strobe |
| cmd_i | input | 8 | Command code |
| wdata_valid_i | input | 1 | Data word strobe |
| wdata_i | input | DW | Data word from host |
| rdata_o | output | DW | Result for the shift register |
| rdata_valid_o | output | 1 | Result load pulse |
| busy_o | output | 1 | Command in progress |
| dbg_active_o | output | 1 | Debug state active |
| illegal_o | output | 1 | Last code was unknown |
| overrun_o | output | 1 | Code arrived while busy |
| go_o | output | 1 | Resume pulse |
| step_o | output | 1 | Single-step pulse |
| tag_go_o | output | 1 | Resume-with-tagging pulse |
| mem_req_o | output | 1 | Memory request |
| mem_gnt_i | input | 1 | Memory grant |
| mem_en_o | output | 1 | Memory access cycle |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | DW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| pc_o | output | DW | Program counter |
| d_o | output | DW | D accumulator |
| x_o | output | DW | X index register |
| y_o | output | DW | Y index register |
| sp_o | output | DW | Stack pointer |

## Verification
If the sequencer is stuck in the wait-for-data or memory-request state, busy_o stays high. Every following code then sets overrun_o on the next cycle, and the expected read results never reach the scoreboard. If the X pointer steps wrongly, the bad address shows as soon as a read-next returns its word, or when X is read back after a write-next. A decode error appears one cycle after the code: either a wrong word on rdata_o, a missing or extra pulse on the run-control outputs, or illegal_o set when it should be clear.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {K_BAD, K_RD, K_WR, K_GO, K_STEP, K_TAG} kind_e;
  typedef enum logic [2:0] {S_MEM, S_PC, S_D, S_X, S_Y, S_SP} sel_e;
  typedef struct packed {
    kind_e kind;
    sel_e  sel;
  } dec_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WDATA, ST_MREQ, ST_MACC} st_e;

  localparam logic [7:0] OP_GO   = 8'h08;
  localparam logic [7:0] OP_STEP = 8'h10;
  localparam logic [7:0] OP_TAG  = 8'h18;
  localparam logic [4:0] OP_WR_HI = 5'b01000; // 0x40..0x47
  localparam logic [4:0] OP_RD_HI = 5'b01100; // 0x60..0x67
endpackage

// File: rtl/dbg_decode.sv
module dbg_decode
  import dbg_pkg::*;
(
  input  logic [7:0] code_i,
  output dec_t       dec_o
);
  logic sel_ok;
  assign sel_ok = code_i[2:0] >= 3'd2;

  always_comb begin
    dec_o.kind = K_BAD;
    dec_o.sel  = sel_e'(code_i[2:0] - 3'd2);
    unique case (code_i)
      OP_GO:   dec_o.kind = K_GO;
      OP_STEP: dec_o.kind = K_STEP;
      OP_TAG:  dec_o.kind = K_TAG;
      default: begin
        if (sel_ok && code_i[7:3] == OP_RD_HI)      dec_o.kind = K_RD;
        else if (sel_ok && code_i[7:3] == OP_WR_HI) dec_o.kind = K_WR;
      end
    endcase
  end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  sel_e          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          x_inc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] sp_o
);
  localparam int NREG = 5;
  localparam int XIDX = 2;

  logic [DW-1:0] r_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        r_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == sel_e'(3'(g + 1)))  r_q[g] <= wr_data_i;
      else if (x_inc_i && g == XIDX)                      r_q[g] <= r_q[g] + DW'(2);
    end
  end

  assign pc_o = r_q[0];
  assign d_o  = r_q[1];
  assign x_o  = r_q[2];
  assign y_o  = r_q[3];
  assign sp_o = r_q[4];
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_i,
  input  logic          wdata_valid_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_valid_o,
  output logic          busy_o,
  output logic          dbg_active_o,
  output logic          illegal_o,
  output logic          overrun_o,
  output logic          go_o,
  output logic          step_o,
  output logic          tag_go_o,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] sp_o
);
  st_e           st_q;
  dec_t          dec;
  sel_e          sel_q;
  logic          we_q, active_q, ill_q, ovr_q, rvalid_q;
  logic          go_q, step_q, tag_q;
  logic [DW-1:0] rdata_q, wbuf_q, rd_val;
  logic          accept, run_acc, data_acc, x_inc, reg_wr;

  dbg_decode u_dec (.code_i(cmd_i), .dec_o(dec));

  assign accept   = cmd_valid_i && active_q && st_q == ST_IDLE;
  assign run_acc  = accept && dec.kind inside {K_GO, K_STEP, K_TAG};
  assign data_acc = st_q == ST_WDATA && wdata_valid_i;
  assign x_inc    = (accept && dec.kind == K_RD && dec.sel == S_MEM) ||
                    (data_acc && sel_q == S_MEM);
  assign reg_wr   = data_acc && sel_q != S_MEM;

  dbg_regfile #(.DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr), .wr_sel_i(sel_q), .wr_data_i(wdata_i), .x_inc_i(x_inc),
    .pc_o, .d_o, .x_o, .y_o, .sp_o
  );

  always_comb begin
    unique case (dec.sel)
      S_PC:    rd_val = pc_o;
      S_D:     rd_val = d_o;
      S_X:     rd_val = x_o;
      S_Y:     rd_val = y_o;
      S_SP:    rd_val = sp_o;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sel_q <= S_MEM; we_q <= 1'b0;
      active_q <= 1'b0; ill_q <= 1'b0; ovr_q <= 1'b0; rvalid_q <= 1'b0;
      go_q <= 1'b0; step_q <= 1'b0; tag_q <= 1'b0;
      rdata_q <= '0; wbuf_q <= '0;
    end else begin
      rvalid_q <= 1'b0;
      go_q <= 1'b0; step_q <= 1'b0; tag_q <= 1'b0;
      if (halt_i && !run_acc) active_q <= 1'b1;
      if (cmd_valid_i && active_q && st_q != ST_IDLE) ovr_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          ill_q <= 1'b0;
          ovr_q <= 1'b0;
          unique case (dec.kind)
            K_RD: if (dec.sel == S_MEM) begin
              we_q <= 1'b0;
              st_q <= ST_MREQ;
            end else begin
              rdata_q  <= rd_val;
              rvalid_q <= 1'b1;
            end
            K_WR:   begin sel_q <= dec.sel; st_q <= ST_WDATA; end
            K_GO:   begin go_q   <= 1'b1; active_q <= 1'b0; end
            K_STEP: begin step_q <= 1'b1; active_q <= 1'b0; end
            K_TAG:  begin tag_q  <= 1'b1; active_q <= 1'b0; end
            default: ill_q <= 1'b1;
          endcase
        end
        ST_WDATA: if (wdata_valid_i) begin
          if (sel_q == S_MEM) begin
            wbuf_q <= wdata_i;
            we_q   <= 1'b1;
            st_q   <= ST_MREQ;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_MREQ: if (mem_gnt_i) st_q <= ST_MACC;
        ST_MACC: begin
          st_q <= ST_IDLE;
          if (!we_q) begin
            rdata_q  <= mem_rdata_i;
            rvalid_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = st_q != ST_IDLE;
  assign dbg_active_o  = active_q;
  assign illegal_o     = ill_q;
  assign overrun_o     = ovr_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign go_o          = go_q;
  assign step_o        = step_q;
  assign tag_go_o      = tag_q;
  assign mem_req_o     = st_q == ST_MREQ;
  assign mem_en_o      = st_q == ST_MACC;
  assign mem_we_o      = mem_en_o && we_q;
  assign mem_addr_o    = mem_en_o ? x_o : '0;
  assign mem_wdata_o   = mem_we_o ? wbuf_q : '0;
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic busy_o,
  input logic dbg_active_o,
  input logic illegal_o,
  input logic go_o,
  input logic step_o,
  input logic tag_go_o,
  input logic mem_req_o,
  input logic mem_gnt_i,
  input logic mem_en_o
);
  // R8
  run_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({go_o, step_o, tag_go_o}));
  // R8
  run_clears_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || step_o || tag_go_o) |-> !dbg_active_o);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o);
  // R7
  en_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> $past(mem_req_o && mem_gnt_i));
  // R10
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R2
  idle_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_active_o |-> !busy_o);
  // R9
  illegal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> $past(cmd_valid_i));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .busy_o(busy_o),
  .dbg_active_o(dbg_active_o), .illegal_o(illegal_o), .go_o(go_o),
  .step_o(step_o), .tag_go_o(tag_go_o), .mem_req_o(mem_req_o),
  .mem_gnt_i(mem_gnt_i), .mem_en_o(mem_en_o)
);

// File: tb/dbg_cmd_engine_tb.sv
`timescale 1ns/1ps
module dbg_cmd_engine_tb;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 1'b0, cmd_valid = 1'b0, wdata_valid = 1'b0, gnt = 1'b0;
  logic [7:0] cmd = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, mem_addr, mem_wdata, mem_rdata, pc, d, x, y, sp;
  logic rvalid, busy, active, illegal, overrun, go, step, tag, mreq, men, mwe;

  always #2.5 clk = ~clk;

  dbg_cmd_engine #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wdata_valid_i(wdata_valid), .wdata_i(wdata), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .busy_o(busy), .dbg_active_o(active), .illegal_o(illegal), .overrun_o(overrun),
    .go_o(go), .step_o(step), .tag_go_o(tag), .mem_req_o(mreq), .mem_gnt_i(gnt),
    .mem_en_o(men), .mem_we_o(mwe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .pc_o(pc), .d_o(d), .x_o(x), .y_o(y), .sp_o(sp)
  );

  int tests = 0, fails = 0, cyc = 0, gnt_delay = 0, gcnt = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_q[$];
  int lim_q[$];
  string tag_q[$];

  function automatic logic [DW-1:0] mem_init(input int idx);
    return 16'hC000 ^ 16'(idx * 3);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (men && mwe) mem[mem_addr[8:1]] <= mem_wdata;
  end

  // grant model: grant after gnt_delay cycles of request
  always @(negedge clk) begin
    if (mreq) begin
      gnt  <= (gcnt >= gnt_delay);
      gcnt <= gcnt + 1;
    end else begin
      gnt  <= 1'b0;
      gcnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each result load
  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_q.size() == 0) chk(1'b0, "R2/R10 unexpected result", 32'(rdata), 32'hx);
    else begin
      automatic logic [DW-1:0] e = exp_q.pop_front();
      automatic int lim = lim_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(rdata === e, t, 32'(rdata), 32'(e));
      chk(cyc <= lim, {t, " latency"}, 32'(cyc), 32'(lim));
    end
  end

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_data(input logic [DW-1:0] v);
    @(negedge clk); wdata_valid = 1'b1; wdata = v;
    @(negedge clk); wdata_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] c, input logic [DW-1:0] v);
    send_cmd(c); send_data(v); wait_idle();
  endtask

  task automatic do_read(input logic [7:0] c, input logic [DW-1:0] e, input int win, input string t);
    exp_q.push_back(e); lim_q.push_back(cyc + win); tag_q.push_back(t);
    send_cmd(c); wait_idle();
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic run_chk(input logic [7:0] c, input logic [2:0] exp_v);
    send_cmd(c);
    chk({go, step, tag} == exp_v, "R8 run pulse", 32'({go, step, tag}), 32'(exp_v));
    chk(!active, "R8 active cleared with pulse", 32'(active), 0);
    @(negedge clk);
    chk({go, step, tag} == 3'b000, "R8 single-cycle pulse", 32'({go, step, tag}), 0);
    send_cmd(8'h63); // ignored while not active
    repeat (2) @(negedge clk);
    pulse_halt();
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({busy, active, illegal, overrun, rvalid, go, step, tag} == 8'h00, "R1 reset outputs",
        32'({busy, active, illegal, overrun, rvalid, go, step, tag}), 0);

    // R2: inactive -> ignored
    send_cmd(8'h63);
    send_cmd(8'h44); send_data(16'hFFFF);
    repeat (3) @(negedge clk);
    chk(!busy && d == 16'h0, "R2 ignored when inactive", 32'(d), 0);
    pulse_halt();
    chk(active, "R2 halt sets active", 32'(active), 1);

    do_read(8'h63, 16'h0000, 32, "R1 PC reset");
    do_read(8'h64, 16'h0000, 32, "R2 D untouched");

    // R3 writes, R4 reads
    do_write(8'h43, 16'h1111);
    do_write(8'h44, 16'h2222);
    do_write(8'h45, 16'h0100);
    do_write(8'h46, 16'h4444);
    do_write(8'h47, 16'h5555);
    do_read(8'h63, 16'h1111, 32, "R3/R4 PC");
    do_read(8'h64, 16'h2222, 32, "R3/R4 D");
    do_read(8'h65, 16'h0100, 32, "R3/R4 X");
    do_read(8'h66, 16'h4444, 32, "R3/R4 Y");
    do_read(8'h67, 16'h5555, 32, "R3/R4 SP");

    // R5 write-next
    gnt_delay = 5;
    do_write(8'h42, 16'hBEEF);
    chk(mem[8'h81] == 16'hBEEF, "R5 memory at X+2", 32'(mem[8'h81]), 32'hBEEF);
    chk(mem[8'h80] == mem_init(8'h80), "R5 old X untouched", 32'(mem[8'h80]), 32'(mem_init(8'h80)));
    do_read(8'h65, 16'h0102, 32, "R5 X advanced");

    // R6 read-next, worst and best grant delays
    gnt_delay = 128;
    do_read(8'h62, mem_init(8'h82), 150, "R6 read-next slow grant");
    gnt_delay = 0;
    do_read(8'h62, mem_init(8'h83), 150, "R6 read-next fast grant");
    do_read(8'h65, 16'h0106, 32, "R6 X advanced twice");

    // R9 illegal code
    send_cmd(8'h55);
    chk(illegal, "R9 illegal flagged", 32'(illegal), 1);
    do_read(8'h63, 16'h1111, 32, "R9 PC unchanged");
    chk(!illegal, "R9 cleared by next code", 32'(illegal), 0);
    send_cmd(8'h61);
    chk(illegal, "R9 0x61 unknown", 32'(illegal), 1);

    // R10 overrun
    send_cmd(8'h44);
    chk(busy, "R10 busy awaiting data", 32'(busy), 1);
    send_cmd(8'h63);
    chk(overrun, "R10 overrun flagged", 32'(overrun), 1);
    send_data(16'h7777);
    wait_idle();
    chk(!busy, "R10 busy released", 32'(busy), 0);
    do_read(8'h64, 16'h7777, 32, "R10 D written after overrun");

    // R8 run control
    run_chk(8'h08, 3'b100);
    run_chk(8'h10, 3'b010);
    run_chk(8'h18, 3'b001);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4/R6 all results seen", 32'(exp_q.size()), 0);
    report();
  end
endmodule